// File: doc/BRIEF.md
# Maskable BCD Alarm Comparator

This block keeps a bank of alarm digits, each one a 4-bit BCD nibble, and compares them with the live time digits each time the timekeeper reports a new time. The alarm covers seconds, minutes, hours, day of week and day of month. The upper bit of each tens digit, and of the day-of-week digit, is a wildcard. When it is set, that whole field is left out of the comparison. Month and year take no part.

When the comparison first becomes true on an update, a sticky alarm flag is set. An interrupt-enable bit sits next to the flag in a small control register. The interrupt output is a registered, active-high level that is the AND of the flag and the enable. Software reads and writes the alarm digits and the control register over a simple register bus made of a bank select, a 4-bit address and 4-bit data. Read data is registered.

Top module: `bcd_alarm_cmp`

## Requirements
- R1: After synchronous reset, all alarm digits, the alarm flag, the interrupt enable, `irq` and `bus_rdata` are 0.
- R2: A write with `bus_bank` = 1 and `bus_addr` 0..8 stores `bus_wdata` in that alarm digit. `bus_rdata` returns the value addressed in the cycle before, one clock later. Digit order by address: 0 s ones, 1 s tens, 2 min ones, 3 min tens, 4 h ones, 5 h tens, 6 day of week, 7 day ones, 8 day tens. `time_digits[4*i+3:4*i]` uses the same order.
- R3: The comparison is evaluated only in cycles where `time_upd` is 1. The flag is set when all fields match on an update and the previous update did not match. The previous-match state is 0 after reset.
- R4: A field matches when bit 3 of its tens digit (or of the day-of-week digit) is 1. Otherwise it matches when the ones digits are equal in all 4 bits and the tens (or day-of-week) digits are equal in bits 2:0.
- R5: The control register sits at bank 1, address 0xE. Bit 0 is the interrupt enable and takes the written value. Writing bit 1 as 0 clears the flag. Writing bit 1 as 1 leaves the flag unchanged and never sets it.
- R6: While the match continues over further updates, a flag that has been cleared is not set again.
- R7: `irq` equals flag AND enable as they stood one clock earlier.
- R8: The control register reads as {0, 0, flag, enable}. Bits 3:2 always read 0.
- R9: Writes to any other bank, or to bank-1 addresses 9..0xD and 0xF, change no alarm digit. Reads there return 0.
- R10: When a flag-setting update and a flag-clearing control write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_upd | input | 1 | Strobe: `time_digits` holds a new time this cycle |
| time_digits | input | 36 | Nine live time BCD digits, digit i at bits 4i+3:4i |
| bus_we | input | 1 | Register write enable |
| bus_bank | input | 2 | Register bank select (alarm bank is 1) |
| bus_addr | input | 4 | Register address within the bank |
| bus_wdata | input | 4 | Register write data |
| bus_rdata | output | 4 | Registered read data for the address of the previous cycle |
| irq | output | 1 | Registered alarm interrupt, active high |

## Verification
The assertions check four things on every cycle: the one-clock relation between `irq` and flag AND enable, that the flag rises only after an update strobe and falls only after a clearing control write, that the alarm digits stay stable without a write, and that reads of the control register and of other banks carry zeros in their unused bits. Several behaviours depend on the history of earlier updates: the rising-edge-only setting of the flag, the wildcard masking of each field, and the precedence of setting over clearing. Only the bench's scenarios show these, running directed sequences and random ones against a reference model of the requirements.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
  // Number of two-digit fields (seconds, minutes, hours, day of month).
  localparam int NPAIR   = 4;
  // Digit index of the day-of-week field.
  localparam int DOW_IDX = 6;

  // Ones-digit index of two-digit field k; its tens digit follows it.
  function automatic int pair_ones(input int k);
    case (k)
      0:       return 0;
      1:       return 2;
      2:       return 4;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/bcd_alarm_regs.sv
module bcd_alarm_regs #(
  parameter int DIGITS     = 9,
  parameter int DW         = 4,
  parameter int AW         = 4,
  parameter int BW         = 2,
  parameter int ALARM_BANK = 1,
  parameter int CTRL_ADDR  = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_we,
  input  logic [BW-1:0]        bus_bank,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  input  logic                 af,
  input  logic                 aie,
  output logic [DIGITS*DW-1:0] alarm_vec,
  output logic                 ctrl_we,
  output logic [DW-1:0]        rdata
);
  logic          bank_hit;
  logic          digit_sel;
  logic          ctrl_sel;
  logic [DW-1:0] rd_next;

  assign bank_hit  = (bus_bank == BW'(ALARM_BANK));
  assign digit_sel = bank_hit && (int'(bus_addr) < DIGITS);
  assign ctrl_sel  = bank_hit && (bus_addr == AW'(CTRL_ADDR));
  assign ctrl_we   = bus_we && ctrl_sel;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    always_ff @(posedge clk) begin
      if (rst)
        alarm_vec[g*DW +: DW] <= '0;
      else if (bus_we && bank_hit && (bus_addr == AW'(g)))
        alarm_vec[g*DW +: DW] <= bus_wdata;
    end
  end

  always_comb begin
    rd_next = '0;
    if (digit_sel)
      rd_next = alarm_vec[int'(bus_addr)*DW +: DW];
    else if (ctrl_sel)
      rd_next = DW'({af, aie});
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match #(
  parameter int DIGITS = 9,
  parameter int DW     = 4
) (
  input  logic [DIGITS*DW-1:0] alarm_vec,
  input  logic [DIGITS*DW-1:0] time_vec,
  output logic                 hit
);
  import bcd_alarm_pkg::*;

  localparam int MSB = DW - 1;

  logic [NPAIR-1:0] pair_ok;
  logic             dow_ok;
  logic             unused_top_bits;

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    localparam int O = pair_ones(g);
    localparam int T = O + 1;
    assign pair_ok[g] = alarm_vec[T*DW+MSB] ||
                        ((alarm_vec[O*DW +: DW]  == time_vec[O*DW +: DW]) &&
                         (alarm_vec[T*DW +: MSB] == time_vec[T*DW +: MSB]));
  end

  assign dow_ok = alarm_vec[DOW_IDX*DW+MSB] ||
                  (alarm_vec[DOW_IDX*DW +: MSB] == time_vec[DOW_IDX*DW +: MSB]);

  assign hit = (&pair_ok) && dow_ok;

  always_comb begin
    unused_top_bits = 1'b0;
    for (int i = 0; i < DIGITS; i++)
      unused_top_bits = unused_top_bits ^ time_vec[i*DW+MSB];
  end
endmodule

// File: rtl/bcd_alarm_flag.sv
module bcd_alarm_flag (
  input  logic       clk,
  input  logic       rst,
  input  logic       time_upd,
  input  logic       hit,
  input  logic       ctrl_we,
  input  logic [1:0] ctrl_wdata,
  output logic       af,
  output logic       aie,
  output logic       irq
);
  logic prev_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      af       <= 1'b0;
      aie      <= 1'b0;
      prev_hit <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= af & aie;
      if (time_upd) prev_hit <= hit;
      if (ctrl_we) begin
        aie <= ctrl_wdata[0];
        if (!ctrl_wdata[1]) af <= 1'b0;
      end
      if (time_upd && hit && !prev_hit) af <= 1'b1;
    end
  end
endmodule

// File: rtl/bcd_alarm_cmp.sv
module bcd_alarm_cmp #(
  parameter int DIGITS     = 9,
  parameter int DW         = 4,
  parameter int AW         = 4,
  parameter int BW         = 2,
  parameter int ALARM_BANK = 1,
  parameter int CTRL_ADDR  = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 time_upd,
  input  logic [DIGITS*DW-1:0] time_digits,
  input  logic                 bus_we,
  input  logic [BW-1:0]        bus_bank,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic                 irq
);
  logic [DIGITS*DW-1:0] alarm_vec;
  logic                 ctrl_we;
  logic                 hit;
  logic                 af_q;
  logic                 aie_q;

  bcd_alarm_regs #(
    .DIGITS(DIGITS), .DW(DW), .AW(AW), .BW(BW),
    .ALARM_BANK(ALARM_BANK), .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_bank(bus_bank),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .af(af_q), .aie(aie_q),
    .alarm_vec(alarm_vec), .ctrl_we(ctrl_we), .rdata(bus_rdata)
  );

  bcd_alarm_match #(.DIGITS(DIGITS), .DW(DW)) u_match (
    .alarm_vec(alarm_vec), .time_vec(time_digits), .hit(hit)
  );

  bcd_alarm_flag u_flag (
    .clk(clk), .rst(rst), .time_upd(time_upd), .hit(hit),
    .ctrl_we(ctrl_we), .ctrl_wdata(bus_wdata[1:0]),
    .af(af_q), .aie(aie_q), .irq(irq)
  );
endmodule

// File: rtl/bcd_alarm_cmp_chk.sv
module bcd_alarm_cmp_chk #(
  parameter int DIGITS     = 9,
  parameter int DW         = 4,
  parameter int AW         = 4,
  parameter int BW         = 2,
  parameter int ALARM_BANK = 1,
  parameter int CTRL_ADDR  = 14
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 time_upd,
  input logic                 bus_we,
  input logic [BW-1:0]        bus_bank,
  input logic [AW-1:0]        bus_addr,
  input logic [DW-1:0]        bus_wdata,
  input logic [DW-1:0]        bus_rdata,
  input logic                 irq,
  input logic                 af,
  input logic                 aie,
  input logic [DIGITS*DW-1:0] alarm_vec
);
  assert_irq_follows_flag_R7: assert property (@(posedge clk) disable iff (rst)
    irq == $past(af & aie));

  assert_flag_rise_on_update_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(af) |-> $past(time_upd));

  assert_flag_fall_on_clear_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(af) |-> $past(bus_we && bus_bank == BW'(ALARM_BANK) &&
                        bus_addr == AW'(CTRL_ADDR) && !bus_wdata[1]));

  assert_ctrl_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
    $past(bus_bank == BW'(ALARM_BANK) && bus_addr == AW'(CTRL_ADDR)) |->
      bus_rdata[DW-1:2] == '0);

  assert_digits_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_we) |-> $stable(alarm_vec));

  assert_other_bank_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
    $past(bus_bank != BW'(ALARM_BANK)) |-> bus_rdata == '0);
endmodule

bind bcd_alarm_cmp bcd_alarm_cmp_chk #(
  .DIGITS(DIGITS), .DW(DW), .AW(AW), .BW(BW),
  .ALARM_BANK(ALARM_BANK), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .time_upd(time_upd), .bus_we(bus_we),
  .bus_bank(bus_bank), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq(irq), .af(af_q), .aie(aie_q),
  .alarm_vec(alarm_vec)
);

// File: tb/sim_bcd_alarm_cmp.sv
`timescale 1ns/1ps
module sim_bcd_alarm_cmp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        time_upd = 1'b0;
  logic [35:0] time_digits = '0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_bank = '0;
  logic [3:0]  bus_addr = '0;
  logic [3:0]  bus_wdata = '0;
  logic [3:0]  bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [35:0] m_al = '0;
  logic        m_af = 0, m_aie = 0, m_prev = 0, m_irq = 0;
  logic [3:0]  m_rd = '0;

  always #2.5 clk = ~clk;

  bcd_alarm_cmp u0 (
    .clk(clk), .rst(rst), .time_upd(time_upd), .time_digits(time_digits),
    .bus_we(bus_we), .bus_bank(bus_bank), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // R4 field rule: wildcard bit 3 of tens, else ones 4 bits and tens 3 bits equal
  function automatic logic fld(input logic [35:0] a, input logic [35:0] t,
                               input int o, input int te);
    return a[te*4+3] || (a[o*4 +: 4] == t[o*4 +: 4] && a[te*4 +: 3] == t[te*4 +: 3]);
  endfunction

  function automatic logic model_hit(input logic [35:0] a, input logic [35:0] t);
    return fld(a, t, 0, 1) && fld(a, t, 2, 3) && fld(a, t, 4, 5) &&
           fld(a, t, 7, 8) && (a[27] || a[26:24] == t[26:24]);
  endfunction

  function automatic logic [35:0] mk(input int s, input int m, input int h,
                                     input int dw, input int d);
    logic [35:0] v;
    v[3:0]   = 4'(s % 10);  v[7:4]   = 4'(s / 10);
    v[11:8]  = 4'(m % 10);  v[15:12] = 4'(m / 10);
    v[19:16] = 4'(h % 10);  v[23:20] = 4'(h / 10);
    v[27:24] = 4'(dw);
    v[31:28] = 4'(d % 10);  v[35:32] = 4'(d / 10);
    return v;
  endfunction

  function automatic logic [3:0] model_read(input logic [1:0] b, input logic [3:0] ad);
    if (b != 2'd1) return 4'h0;
    if (ad < 4'd9) return m_al[ad*4 +: 4];
    if (ad == 4'hE) return {2'b00, m_af, m_aie};
    return 4'h0;
  endfunction

  task automatic check(input logic c, input string tag, input int act, input int exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, model at posedge, check at next negedge.
  task automatic step(input logic we, input logic [1:0] b, input logic [3:0] ad,
                      input logic [3:0] wd, input logic upd, input logic [35:0] td,
                      input string tag);
    logic h, set;
    bus_we = we; bus_bank = b; bus_addr = ad; bus_wdata = wd;
    time_upd = upd; time_digits = td;
    @(posedge clk);
    m_irq = m_af & m_aie;
    m_rd  = model_read(b, ad);
    h     = model_hit(m_al, td);
    set   = upd && h && !m_prev;
    if (upd) m_prev = h;
    if (we && b == 2'd1 && ad == 4'hE) begin
      m_aie = wd[0];
      if (!wd[1]) m_af = 1'b0;
    end
    if (set) m_af = 1'b1;
    if (we && b == 2'd1 && ad < 4'd9) m_al[ad*4 +: 4] = wd;
    @(negedge clk);
    check(bus_rdata === m_rd, tag, int'(bus_rdata), int'(m_rd));
    check(irq === m_irq, "R7 irq", int'(irq), int'(m_irq));
  endtask

  task automatic wr(input logic [3:0] ad, input logic [3:0] wd, input string tag);
    step(1'b1, 2'd1, ad, wd, 1'b0, time_digits, tag);
  endtask

  task automatic rd(input logic [3:0] ad, input string tag);
    step(1'b0, 2'd1, ad, 4'h0, 1'b0, time_digits, tag);
    step(1'b0, 2'd1, ad, 4'h0, 1'b0, time_digits, tag);
  endtask

  task automatic tick(input logic [35:0] td, input string tag);
    step(1'b0, 2'd1, 4'hE, 4'h0, 1'b1, td, tag);
  endtask

  initial begin
    logic [35:0] tm, alarm_set;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(bus_rdata === 4'h0, "R1 rdata after reset", int'(bus_rdata), 0);
    check(irq === 1'b0, "R1 irq after reset", int'(irq), 0);
    for (int i = 0; i < 9; i++) rd(4'(i), "R1 digit reset");
    rd(4'hE, "R1 ctrl reset");

    // alarm 19th, dow wildcard, 12:34:56
    alarm_set = mk(56, 34, 12, 8, 19);
    for (int i = 0; i < 9; i++) wr(4'(i), alarm_set[i*4 +: 4], "R2 write");
    for (int i = 0; i < 9; i++) rd(4'(i), "R2 readback");
    tm = mk(56, 34, 12, 3, 19);
    tick(mk(57, 34, 12, 3, 19), "R3 mismatch");
    rd(4'hE, "R3 no flag on mismatch");
    tick(tm, "R3 match");
    rd(4'hE, "R3 flag set");
    wr(4'hE, 4'b0011, "R5 enable keep flag");
    rd(4'hE, "R8 ctrl readback");
    wr(4'hE, 4'b0001, "R5 clear flag");
    tick(tm, "R6 continuing match");
    tick(tm, "R6 continuing match");
    rd(4'hE, "R6 flag stays clear");
    wr(4'hE, 4'b0011, "R5 write one no set");
    rd(4'hE, "R5 flag not set by write");
    tick(mk(56, 34, 11, 3, 19), "R3 mismatch");
    tick(mk(56, 34, 12, 5, 19), "R4 dow wildcard match");
    rd(4'hE, "R4 flag after wildcard");
    tick(mk(0, 0, 0, 0, 1), "R10 prep mismatch");
    step(1'b1, 2'd1, 4'hE, 4'b0001, 1'b1, tm, "R10 set beats clear");
    rd(4'hE, "R10 flag set");
    step(1'b1, 2'd0, 4'h0, 4'hF, 1'b0, tm, "R9 other bank write");
    for (int a = 9; a < 16; a++)
      if (a != 14) wr(4'(a), 4'hF, "R9 unused addr write");
    for (int i = 0; i < 9; i++) rd(4'(i), "R9 digits unchanged");
    step(1'b0, 2'd2, 4'h0, 4'h0, 1'b0, tm, "R9 other bank read");
    step(1'b0, 2'd3, 4'hE, 4'h0, 1'b0, tm, "R9 other bank read");
    wr(4'hE, 4'b0000, "R5 clear");
    wr(4'd1, 4'h8, "R4 mask seconds");
    tick(mk(0, 0, 0, 0, 1), "R3 mismatch");
    tick(mk(3, 34, 12, 1, 19), "R4 seconds wildcard");
    rd(4'hE, "R4 flag after seconds wildcard");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [35:0] td;
      logic [1:0] b;
      op = int'($urandom % 8);
      b  = ($urandom % 4 == 0) ? 2'($urandom) : 2'd1;
      td = m_al;
      if ($urandom % 3 == 0) td[($urandom % 9)*4 +: 4] = 4'($urandom);
      if ($urandom % 4 == 0) td = 36'($urandom) ^ {4'($urandom), 32'd0};
      case (op)
        0, 1: step(1'b1, 2'd1, 4'($urandom % 9), 4'($urandom), 1'b0, td, "R2 random");
        2:    step(1'b1, 2'd1, 4'hE, 4'($urandom), $urandom % 2 == 0, td, "R5 random");
        3:    step(1'b1, b, 4'($urandom), 4'($urandom), 1'b0, td, "R9 random");
        default: step(1'b0, b, 4'($urandom), 4'h0, 1'b1, td, "R3 random");
      endcase
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", checks, errors);
      $finish;
    end
  end
endmodule